// File: doc/BRIEF.md
# Single-Cycle 32-bit Register Machine Core

This block is a compact processor core that completes one instruction per clock. It keeps its program and its data in two on-block word arrays, holds eight 32-bit general registers and a word-addressed program counter, and understands three kinds of instruction: word transfers between memory and registers, two-operand register arithmetic and logic, and a conditional branch taken when two registers hold the same value. Anything it does not recognise falls through as a no-op.

Both arrays are filled through a small preload port. The port is live only while reset is held, so a host or bench holds the core in reset, writes the program and the initial data, then releases reset. Execution starts at word 0 on the first rising edge after release. A debug port shows the program counter and, through a 3-bit selector, the current value of any register. Both are driven by combinational logic from state, so they show the effect of an instruction as soon as the edge that retires it has passed.

Top module: `mini_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all eight registers become 0. The data array keeps its contents.
- R2: A preload write (`load_we` high, `load_sel` 0 = program array, 1 = data array, word `load_addr`, value `load_data`) takes effect only at an edge where `rst` is high. At any other edge it changes neither array.
- R3: Instruction layout: [31:30] class (00 memory, 01 ALU, 10 branch-if-equal, 11 reserved), [29:27] destination rd, [26:24] source rs, [23:21] source rt, [20:18] function code, [17:16] reserved and required to be zero, [15:0] signed immediate.
- R4: ALU class functions 000 ADD, 001 SUB (rs minus rt), 010 OR, 011 XOR and 100 AND write the 32-bit result, wrapping on overflow, to rd.
- R5: ALU function 101 (compare) writes 1 to rd when rs is less than rt as signed 32-bit numbers, and 0 otherwise.
- R6: Memory function 000 (load word) writes to rd the data word at index (rs + sign-extended immediate) modulo the data depth.
- R7: Memory function 001 (store word) writes rt to the data word at the same computed index at the rising edge, and changes no register.
- R8: Branch-if-equal sets the PC to PC+1+sign-extended immediate when rs equals rt, and to PC+1 otherwise. It never writes a register or memory.
- R9: A reserved class, ALU functions 110/111, memory functions other than 000/001, and any instruction with nonzero bits [17:16] only advance the PC.
- R10: Every non-branch instruction sets the PC to PC+1. `dbg_pc` shows the PC, zero-extended, and `dbg_reg` shows register `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables preload |
| load_we | input | 1 | Preload write strobe |
| load_sel | input | 1 | Preload target: 0 program array, 1 data array |
| load_addr | input | 6 | Preload word index |
| load_data | input | 32 | Preload word value |
| dbg_sel | input | 3 | Register selected for observation |
| dbg_pc | output | 32 | Current program counter |
| dbg_reg | output | 32 | Value of the selected register |

## Verification
The hardest states to reach from the ports are those where the data array or a register must be proven unchanged. A store leaves no trace on the debug port, so the program reads the stored word back with a later load. A taken branch is exposed by planting register-writing instructions in the skipped words and then confirming that the target register still holds its old value. A preload attempted while the core runs is shown to be ignored in two ways: a rewritten program word still executes as originally loaded, and after a fresh reset the load of data word 0 still returns its original value.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 8;
    localparam int RIDX = $clog2(NREG);
    localparam int IMMW = 16;
    localparam int FNW  = 3;

    typedef enum logic [1:0] {
        CLS_MEM = 2'b00,
        CLS_ALU = 2'b01,
        CLS_BEQ = 2'b10,
        CLS_RSV = 2'b11
    } cls_e;

    typedef enum logic [FNW-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_OR  = 3'd2,
        OP_XOR = 3'd3,
        OP_AND = 3'd4,
        OP_SLT = 3'd5
    } alu_op_e;

    localparam logic [FNW-1:0] MFN_LOAD  = 3'd0;
    localparam logic [FNW-1:0] MFN_STORE = 3'd1;
    localparam logic [FNW-1:0] ALU_LAST  = 3'd5;

    typedef struct packed {
        cls_e            cls;
        logic [RIDX-1:0] rd;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [FNW-1:0]  fn;
        logic [1:0]      rsv;
        logic [IMMW-1:0] imm;
    } instr_t;

    typedef struct packed {
        logic    rf_we;
        logic    wb_mem;
        logic    dm_we;
        logic    br_eq;
        alu_op_e op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction

endpackage

// File: rtl/mcpu_decode.sv
module mcpu_decode
    import mcpu_pkg::*;
(
    input  cls_e           cls,
    input  logic [FNW-1:0] fn,
    input  logic [1:0]     rsv,
    output ctrl_t          ctl
);

    always_comb begin
        ctl    = '0;
        ctl.op = OP_ADD;
        if (rsv == 2'b00) begin
            unique case (cls)
                CLS_MEM: begin
                    if (fn == MFN_LOAD) begin
                        ctl.rf_we  = 1'b1;
                        ctl.wb_mem = 1'b1;
                    end else if (fn == MFN_STORE) begin
                        ctl.dm_we = 1'b1;
                    end
                end
                CLS_ALU: begin
                    if (fn <= ALU_LAST) begin
                        ctl.rf_we = 1'b1;
                        ctl.op    = alu_op_e'(fn);
                    end
                end
                CLS_BEQ: ctl.br_eq = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile
    import mcpu_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = XLEN,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_dbg,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_dbg
);

    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && wa == AW'(g)) begin
                regs[g] <= wd;
            end
        end
    end

    assign rd_a   = regs[ra_a];
    assign rd_b   = regs[ra_b];
    assign rd_dbg = regs[ra_dbg];

endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
    import mcpu_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_AND:  y = a & b;
            OP_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/mini_cpu.sv
module mini_cpu
    import mcpu_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_we,
    input  logic            load_sel,
    input  logic [LAW-1:0]  load_addr,
    input  logic [XLEN-1:0] load_data,
    input  logic [RIDX-1:0] dbg_sel,
    output logic [XLEN-1:0] dbg_pc,
    output logic [XLEN-1:0] dbg_reg
);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [IAW-1:0]  pc_q;
    logic [IAW-1:0]  pc_d;
    logic [XLEN-1:0] pc_ext;
    instr_t          instr;
    ctrl_t           ctl;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] imm_x;
    logic [DAW-1:0]  ea;
    logic [XLEN-1:0] wb_val;
    logic            rf_we;
    logic            dm_we;
    logic            take_br;

    // Fetch: program word addressed by the PC
    assign instr  = instr_t'(imem[pc_q]);
    assign pc_ext = {{(XLEN-IAW){1'b0}}, pc_q};
    assign imm_x  = sext_imm(instr.imm);

    mcpu_decode u_dec (
        .cls (instr.cls),
        .fn  (instr.fn),
        .rsv (instr.rsv),
        .ctl (ctl)
    );

    assign rf_we = ctl.rf_we;
    assign dm_we = ctl.dm_we;

    mcpu_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .wa     (instr.rd),
        .wd     (wb_val),
        .ra_a   (instr.rs),
        .ra_b   (instr.rt),
        .ra_dbg (dbg_sel),
        .rd_a   (rs_val),
        .rd_b   (rt_val),
        .rd_dbg (dbg_reg)
    );

    mcpu_alu u_alu (
        .op (ctl.op),
        .a  (rs_val),
        .b  (rt_val),
        .y  (alu_y)
    );

    // Effective word index, wrapped to the data depth
    assign ea     = DAW'(rs_val + imm_x);
    assign wb_val = ctl.wb_mem ? dmem[ea] : alu_y;

    // Next PC
    assign take_br = ctl.br_eq && (rs_val == rt_val);
    always_comb begin
        if (take_br) begin
            pc_d = IAW'(pc_ext + XLEN'(1) + imm_x);
        end else begin
            pc_d = IAW'(pc_ext + XLEN'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    // Program array: written only by preload during reset
    always_ff @(posedge clk) begin
        if (rst && load_we && !load_sel) begin
            imem[load_addr[IAW-1:0]] <= load_data;
        end
    end

    // Data array: preload during reset, stores while running
    always_ff @(posedge clk) begin
        if (rst) begin
            if (load_we && load_sel) begin
                dmem[load_addr[DAW-1:0]] <= load_data;
            end
        end else if (dm_we) begin
            dmem[ea] <= rt_val;
        end
    end

    assign dbg_pc = pc_ext;

endmodule

// File: rtl/mini_cpu_chk.sv
module mini_cpu_chk #(
    parameter int IAW = 6,
    parameter int W   = 32
) (
    input logic           clk,
    input logic           rst,
    input logic [IAW-1:0] pc_q,
    input logic [1:0]     cls,
    input logic [W-1:0]   rs_val,
    input logic [W-1:0]   rt_val,
    input logic           rf_we,
    input logic           dm_we
);

    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    // R1
    reset_pc_chk: assert property (@(posedge clk) rst |=> (pc_q == '0));

    // R10
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (cls != 2'b10) |=> (pc_q == $past(pc_q) + IAW'(1)));

    // R8
    beq_miss_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (cls == 2'b10 && rs_val != rt_val) |=> (pc_q == $past(pc_q) + IAW'(1)));

    // R8
    beq_nowrite_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (cls == 2'b10) |-> (!rf_we && !dm_we));

    // R9
    rsv_nowrite_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (cls == 2'b11) |-> (!rf_we && !dm_we));

endmodule

bind mini_cpu mini_cpu_chk #(.IAW(IAW), .W(mcpu_pkg::XLEN)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .pc_q   (pc_q),
    .cls    (instr.cls),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .rf_we  (rf_we),
    .dm_we  (dm_we)
);

// File: tb/tb_mini_cpu.sv
`timescale 1ns/1ps
module tb_mini_cpu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_we = 1'b0;
    logic        load_sel = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [2:0]  dbg_sel = '0;
    logic [31:0] dbg_pc;
    logic [31:0] dbg_reg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mini_cpu dut (
        .clk       (clk),
        .rst       (rst),
        .load_we   (load_we),
        .load_sel  (load_sel),
        .load_addr (load_addr),
        .load_data (load_data),
        .dbg_sel   (dbg_sel),
        .dbg_pc    (dbg_pc),
        .dbg_reg   (dbg_reg)
    );

    function automatic logic [31:0] enc(input logic [1:0] c, input logic [2:0] rd,
        input logic [2:0] rs, input logic [2:0] rt, input logic [2:0] fn,
        input logic [1:0] rv, input logic [15:0] imm);
        return {c, rd, rs, rt, fn, rv, imm};
    endfunction

    typedef struct packed {
        logic [5:0]  addr;
        logic [31:0] ins;
        logic [3:0]  req;
        logic [2:0]  sel;
        logic [5:0]  pc;
        logic [31:0] val;
    } vec_t;

    // Data preload: d0=5, d1=-3, d2=0xF0, d3=0xFF0
    localparam vec_t VEC [22] = '{
        '{6'd0,  enc(0,1,0,0,0,0,16'd0),      4'd6,  3'd1, 6'd1,  32'd5},        // R6
        '{6'd1,  enc(0,2,0,0,0,0,16'd1),      4'd6,  3'd2, 6'd2,  32'hFFFFFFFD}, // R6
        '{6'd2,  enc(0,3,0,0,0,0,16'd2),      4'd6,  3'd3, 6'd3,  32'h000000F0}, // R6
        '{6'd3,  enc(0,4,0,0,0,0,16'd3),      4'd6,  3'd4, 6'd4,  32'h00000FF0}, // R6
        '{6'd4,  enc(1,5,1,2,0,0,16'd0),      4'd4,  3'd5, 6'd5,  32'd2},        // R4 ADD wraps
        '{6'd5,  enc(1,6,1,2,1,0,16'd0),      4'd4,  3'd6, 6'd6,  32'd8},        // R4 SUB
        '{6'd6,  enc(1,7,3,4,2,0,16'd0),      4'd4,  3'd7, 6'd7,  32'h00000FF0}, // R4 OR
        '{6'd7,  enc(1,7,3,4,3,0,16'd0),      4'd4,  3'd7, 6'd8,  32'h00000F00}, // R4 XOR
        '{6'd8,  enc(1,7,3,4,4,0,16'd0),      4'd4,  3'd7, 6'd9,  32'h000000F0}, // R4 AND
        '{6'd9,  enc(1,6,2,1,5,0,16'd0),      4'd5,  3'd6, 6'd10, 32'd1},        // R5 -3<5
        '{6'd10, enc(1,6,1,2,5,0,16'd0),      4'd5,  3'd6, 6'd11, 32'd0},        // R5 5<-3 false
        '{6'd11, enc(0,3,1,5,1,0,16'hFFFC),   4'd7,  3'd3, 6'd12, 32'h000000F0}, // R7 store, rd untouched
        '{6'd12, enc(0,6,0,0,0,0,16'd1),      4'd7,  3'd6, 6'd13, 32'd2},        // R7 read back
        '{6'd13, enc(2,0,1,2,0,0,16'd5),      4'd8,  3'd1, 6'd14, 32'd5},        // R8 not taken
        '{6'd14, enc(2,7,0,0,0,0,16'd2),      4'd8,  3'd7, 6'd17, 32'h000000F0}, // R8 taken
        '{6'd17, enc(3,7,1,1,0,0,16'd0),      4'd9,  3'd7, 6'd18, 32'h000000F0}, // R9 class 11
        '{6'd18, enc(1,1,2,2,6,0,16'd0),      4'd9,  3'd1, 6'd19, 32'd5},        // R9 ALU fn 6
        '{6'd19, enc(0,1,0,0,2,0,16'd0),      4'd9,  3'd1, 6'd20, 32'd5},        // R9 memory fn 2
        '{6'd20, enc(1,1,1,1,0,1,16'd0),      4'd9,  3'd1, 6'd21, 32'd5},        // R9 reserved bits
        '{6'd21, enc(2,0,0,0,0,0,16'hFFEA),   4'd8,  3'd0, 6'd0,  32'd0},        // R8 backward
        '{6'd15, enc(1,7,1,1,0,0,16'd0),      4'd8,  3'd7, 6'd0,  32'd0},        // trap, skipped
        '{6'd16, enc(1,7,1,1,0,0,16'd0),      4'd8,  3'd7, 6'd0,  32'd0}         // trap, skipped
    };
    localparam int NRUN = 20;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic preload(input logic sel, input logic [5:0] a, input logic [31:0] d);
        load_we   = 1'b1;
        load_sel  = sel;
        load_addr = a;
        load_data = d;
        step();
        load_we = 1'b0;
    endtask

    task automatic check_reset_state();
        check("R1 pc", dbg_pc, 32'd0);
        for (int r = 0; r < 8; r++) begin
            dbg_sel = 3'(r);
            #1;
            check("R1 reg", dbg_reg, 32'd0);
        end
    endtask

    initial begin
        step();
        step();
        // R1: reset state
        check_reset_state();

        // R2: preload during reset
        preload(1'b1, 6'd0, 32'd5);
        preload(1'b1, 6'd1, 32'hFFFFFFFD);
        preload(1'b1, 6'd2, 32'h000000F0);
        preload(1'b1, 6'd3, 32'h00000FF0);
        for (int i = 0; i < 22; i++) begin
            preload(1'b0, VEC[i].addr, VEC[i].ins);
        end

        // R3 R10: walk the program, one instruction per cycle
        rst = 1'b0;
        for (int i = 0; i < NRUN; i++) begin
            dbg_sel = VEC[i].sel;
            step();
            check($sformatf("R%0d R10 pc", VEC[i].req), dbg_pc, {26'd0, VEC[i].pc});
            check($sformatf("R%0d reg", VEC[i].req), dbg_reg, VEC[i].val);
        end

        // R2: writes while running are ignored (pc=0, then pc=1)
        load_we   = 1'b1;
        load_sel  = 1'b1;
        load_addr = 6'd0;
        load_data = 32'd99;
        dbg_sel   = 3'd1;
        step();
        check("R2 load during run", dbg_reg, 32'd5);
        load_sel  = 1'b0;
        load_addr = 6'd2;
        load_data = enc(1,3,1,1,0,0,16'd0);
        step();
        load_we = 1'b0;
        dbg_sel = 3'd3;
        step();
        check("R2 program unchanged", dbg_reg, 32'h000000F0);
        check("R10 pc", dbg_pc, 32'd3);

        // R1: reset in the middle of a run
        rst = 1'b1;
        step();
        check_reset_state();
        rst = 1'b0;
        dbg_sel = 3'd1;
        step();
        check("R2 data word 0 kept", dbg_reg, 32'd5);
        check("R10 pc", dbg_pc, 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule